// File: doc/BRIEF.md
# CPU Clock Source Switch Controller

This block chooses the clock that drives the CPU. There are two candidates. The first is the main clock, taken through a power-of-two divider. The second is a slow subsystem clock. Software controls the choice through one 8-bit control word.

A write that changes the requested source does not act at once. The CPU keeps running on the old clock for a fixed number of its rising edges. After that, the multiplexer waits until both candidate clocks are low and then changes over, so no runt pulse appears. Software learns which source is actually driving the CPU from a separate read-only status bit, not from the bit it wrote.

While the subsystem clock is active:
- the divider field has no effect on the CPU clock,
- the watchdog count enable is held off,
- the main oscillator may be stopped,
- a request to enter stop mode is refused and flagged.

All logic runs on `clk`. `clk` also serves as the main oscillator that feeds the divider. The subsystem clock enters as a level on `sub_clk` and is sampled on `clk`.

Top module: `cpuclk_src_ctrl`

## Requirements
- R1: After reset, the control word reads 0x04. The CPU clock runs from the main source with a period of 32 `clk` cycles. `wdt_cnt_en` and `main_osc_en` are 1, and `stop_grant` and `stop_err` are 0.
- R2: Bits [2:0] hold the ratio code k. Codes 0 to 4 are accepted and read back. While the main source is active, each gives a CPU clock period of 2^(k+1) `clk` cycles.
- R3: A write with bits [2:0] equal to 5, 6 or 7 leaves the stored ratio code, its readback and the CPU clock period unchanged. The other fields of that write still take effect.
- R4: Bit 4 is the requested source (0 = main, 1 = subsystem) and reads back as written. Bit 5 reads 1 only while the subsystem clock drives the CPU. A write does not change bit 5 at once: at least 4 rising edges of the old CPU clock occur before bit 5 follows.
- R5: The source changes over only while both candidate clocks are low. Across a changeover, no high pulse of `cpu_clk` is shorter than the shorter half-period of the two sources.
- R6: While the subsystem source is active, `cpu_clk` has the period of `sub_clk`. Writes to bits [2:0] are stored but do not change `cpu_clk`.
- R7: `wdt_cnt_en` is 0 exactly while the subsystem source is active.
- R8: Bit 7 is the oscillator stop. A write sets it only while the subsystem source is active and only if the same write has bit 4 = 1; any other write clears it. `main_osc_en` is the inverse of bit 7, and the divided main clock stays halted while the stop is set.
- R9: A one-cycle `stop_req` on the main source gives a one-cycle `stop_grant` on the next cycle. On the subsystem source it gives no grant and sets `stop_err`, which stays set until reset.
- R10: `rst_n` asserts asynchronously. Its release is synchronised over two `clk` edges, and writes presented during those two edges are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock, also the main oscillator feeding the divider |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| sub_clk | input | 1 | Subsystem clock level |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 8 | Control word write value |
| rd_data | output | 8 | Control word readback, including the status bit |
| stop_req | input | 1 | Request to enter stop mode |
| cpu_clk | output | 1 | Selected CPU clock |
| wdt_cnt_en | output | 1 | Watchdog count enable |
| main_osc_en | output | 1 | Main oscillator run enable |
| stop_grant | output | 1 | One-cycle stop acceptance |
| stop_err | output | 1 | Sticky flag for a refused stop request |

## Verification
The bench counts old-clock rising edges between the write and the status flip in both directions. A design that switched straight away, or that let the status bit mirror the request, shows fewer than four edges.

It also tracks the shortest high pulse of `cpu_clk` across a changeover from a fast main ratio to the slow source. A multiplexer that changed over while either input was high would cut a pulse short.

The remaining directed cases each expose a specific fault:
- Reserved ratio codes: a design that loaded them would change the period.
- Divider writes while on the slow clock: a design that honoured them would change the period.
- An oscillator stop written while on the main clock: a design that accepted it would kill the clock.
- A stop request on the slow clock: a design that granted it would assert `stop_grant` and leave `stop_err` clear.
- Writes overlapping reset release: a design without release synchronisation would take the write.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;
  localparam int CC_DIV_W       = 3;
  localparam int CC_N_RATIO     = 5;
  localparam int CC_DEFER_EDGES = 4;
  localparam int CC_WORD_W      = 8;
  localparam int CC_BIT_SRC_REQ = 4;
  localparam int CC_BIT_SRC_ACT = 5;
  localparam int CC_BIT_OSC_OFF = 7;

  typedef enum logic [1:0] {
    SW_IDLE  = 2'd0,
    SW_DEFER = 2'd1,
    SW_ALIGN = 2'd2
  } cc_sw_state_e;
endpackage

// File: rtl/cpuclk_main_div.sv
module cpuclk_main_div #(
  parameter int DIV_W   = 3,
  parameter int N_RATIO = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_sel,
  output logic             main_lvl
);
  localparam int CNT_W = (N_RATIO > 1) ? N_RATIO - 1 : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, half_lim;
  logic             lvl_q, lvl_d;

  // half period of code k is 2^k cycles, so the terminal count is 2^k - 1
  always_comb begin
    half_lim = '0;
    for (int i = 0; i < CNT_W; i++) begin
      if (i < int'(div_sel)) half_lim[i] = 1'b1;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (!run) begin
      cnt_d = '0;
      lvl_d = 1'b0;
    end else if (cnt_q >= half_lim) begin
      cnt_d = '0;
      lvl_d = ~lvl_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign main_lvl = lvl_q;

  AST_HALT_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvl_q) |-> $past(run)); // R8
endmodule

// File: rtl/cpuclk_src_mux.sv
module cpuclk_src_mux
  import cpuclk_pkg::*;
#(
  parameter int DEFER_EDGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_req,
  input  logic main_lvl,
  input  logic sub_lvl,
  output logic src_act,
  output logic cpu_clk
);
  localparam int EC_W = $clog2(DEFER_EDGES + 1);

  cc_sw_state_e    state_q, state_d;
  logic [EC_W-1:0] ecnt_q, ecnt_d;
  logic            cls_q, cls_d;
  logic            sub_q;
  logic            cpu_q, cpu_d;
  logic            prev_q;
  logic            rise;

  assign rise = cpu_q & ~prev_q;

  always_comb begin
    state_d = state_q;
    ecnt_d  = ecnt_q;
    cls_d   = cls_q;
    case (state_q)
      SW_IDLE: begin
        if (src_req != cls_q) begin
          state_d = SW_DEFER;
          ecnt_d  = '0;
        end
      end
      SW_DEFER: begin
        if (src_req == cls_q) begin
          state_d = SW_IDLE;
        end else if (rise) begin
          ecnt_d = ecnt_q + 1'b1;
          if (ecnt_q == EC_W'(DEFER_EDGES - 1)) state_d = SW_ALIGN;
        end
      end
      SW_ALIGN: begin
        if (src_req == cls_q) begin
          state_d = SW_IDLE;
          ecnt_d  = '0;
        end else if (!main_lvl && !sub_q) begin
          cls_d   = ~cls_q;
          state_d = SW_IDLE;
          ecnt_d  = '0;
        end
      end
      default: state_d = SW_IDLE;
    endcase
    cpu_d = cls_d ? sub_q : main_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SW_IDLE;
      ecnt_q  <= '0;
      cls_q   <= 1'b0;
      sub_q   <= 1'b0;
      cpu_q   <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ecnt_q  <= ecnt_d;
      cls_q   <= cls_d;
      sub_q   <= sub_lvl;
      cpu_q   <= cpu_d;
      prev_q  <= cpu_q;
    end
  end

  assign src_act = cls_q;
  assign cpu_clk = cpu_q;

  AST_SWITCH_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cls_q) |-> !cpu_q); // R5
  AST_DEFER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SW_ALIGN) |-> (ecnt_q == EC_W'(DEFER_EDGES))); // R4
endmodule

// File: rtl/cpuclk_src_ctrl.sv
module cpuclk_src_ctrl
  import cpuclk_pkg::*;
#(
  parameter int DIV_W       = CC_DIV_W,
  parameter int N_RATIO     = CC_N_RATIO,
  parameter int DEFER_EDGES = CC_DEFER_EDGES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sub_clk,
  input  logic                 wr_en,
  input  logic [CC_WORD_W-1:0] wr_data,
  output logic [CC_WORD_W-1:0] rd_data,
  input  logic                 stop_req,
  output logic                 cpu_clk,
  output logic                 wdt_cnt_en,
  output logic                 main_osc_en,
  output logic                 stop_grant,
  output logic                 stop_err
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_i;
  logic [DIV_W-1:0] div_sel_q, div_sel_d;
  logic             css_q, css_d;
  logic             mstop_q, mstop_d;
  logic             grant_q, grant_d;
  logic             err_q, err_d;
  logic             cls_w;
  logic             main_lvl_w;
  logic             unused_wr_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  always_comb begin
    div_sel_d = div_sel_q;
    css_d     = css_q;
    mstop_d   = mstop_q;
    if (wr_en) begin
      if (wr_data[DIV_W-1:0] < DIV_W'(N_RATIO)) div_sel_d = wr_data[DIV_W-1:0];
      css_d   = wr_data[CC_BIT_SRC_REQ];
      mstop_d = wr_data[CC_BIT_OSC_OFF] & wr_data[CC_BIT_SRC_REQ] & cls_w;
    end
    grant_d = stop_req & ~cls_w;
    err_d   = err_q | (stop_req & cls_w);
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      div_sel_q <= DIV_W'(N_RATIO - 1);
      css_q     <= 1'b0;
      mstop_q   <= 1'b0;
      grant_q   <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      div_sel_q <= div_sel_d;
      css_q     <= css_d;
      mstop_q   <= mstop_d;
      grant_q   <= grant_d;
      err_q     <= err_d;
    end
  end

  cpuclk_main_div #(
    .DIV_W   (DIV_W),
    .N_RATIO (N_RATIO)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .run      (~mstop_q),
    .div_sel  (div_sel_q),
    .main_lvl (main_lvl_w)
  );

  cpuclk_src_mux #(
    .DEFER_EDGES (DEFER_EDGES)
  ) u_mux (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .src_req  (css_q),
    .main_lvl (main_lvl_w),
    .sub_lvl  (sub_clk),
    .src_act  (cls_w),
    .cpu_clk  (cpu_clk)
  );

  always_comb begin
    rd_data                 = '0;
    rd_data[DIV_W-1:0]      = div_sel_q;
    rd_data[CC_BIT_SRC_REQ] = css_q;
    rd_data[CC_BIT_SRC_ACT] = cls_w;
    rd_data[CC_BIT_OSC_OFF] = mstop_q;
  end

  assign unused_wr_bits = ^{wr_data[CC_WORD_W-2:CC_BIT_SRC_ACT], wr_data[CC_BIT_SRC_REQ-1:DIV_W]};
  assign wdt_cnt_en     = ~cls_w;
  assign main_osc_en    = ~mstop_q;
  assign stop_grant     = grant_q;
  assign stop_err       = err_q;

  AST_OSC_STOP_ON_SUB: assert property (@(posedge clk) disable iff (!rst_n_i)
    mstop_q |-> cls_w); // R8
  AST_DIV_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n_i)
    div_sel_q < DIV_W'(N_RATIO)); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n_i)
    err_q |=> err_q); // R9
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(err_q) |-> $past(stop_req)); // R9
endmodule

// File: tb/cpuclk_src_ctrl_bench.sv
`timescale 1ns/1ps
module cpuclk_src_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sub_clk = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       stop_req = 1'b0;
  logic [7:0] rd_data;
  logic       cpu_clk, wdt_cnt_en, main_osc_en, stop_grant, stop_err;

  int n_run = 0;
  int n_fail = 0;
  int hi_run = 0;
  int min_hi = 1000;
  bit mon_en = 1'b0;
  logic prev_cpu = 1'b0;

  localparam logic [7:0] VW [0:7] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h07, 8'h02};
  localparam int         VD [0:7] = '{0, 1, 2, 3, 4, 4, 4, 2};
  localparam int         VP [0:7] = '{2, 4, 8, 16, 32, 32, 32, 8};

  cpuclk_src_ctrl u_cpuclk_src_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .sub_clk     (sub_clk),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .stop_req    (stop_req),
    .cpu_clk     (cpu_clk),
    .wdt_cnt_en  (wdt_cnt_en),
    .main_osc_en (main_osc_en),
    .stop_grant  (stop_grant),
    .stop_err    (stop_err)
  );

  always #2.5 clk = ~clk;

  always begin
    repeat (8) @(negedge clk);
    sub_clk = ~sub_clk;
  end

  always @(negedge clk) begin
    if (cpu_clk) begin
      hi_run = hi_run + 1;
    end else begin
      if (prev_cpu && mon_en && hi_run < min_hi) min_hi = hi_run;
      hi_run = 0;
    end
    prev_cpu = cpu_clk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_rise();
    logic p;
    p = cpu_clk;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (cpu_clk && !p) break;
      p = cpu_clk;
    end
  endtask

  task automatic measure(output int per);
    logic p;
    wait_rise();
    wait_rise();
    per = 0;
    p = cpu_clk;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      per++;
      if (cpu_clk && !p) break;
      p = cpu_clk;
    end
  endtask

  task automatic rises_until(input logic st, output int rises);
    logic p;
    rises = 0;
    p = cpu_clk;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (cpu_clk && !p) rises++;
      p = cpu_clk;
      if (rd_data[5] == st) break;
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not complete actual=0 expected=1");
    summary();
  end

  initial begin
    int per;
    int rises;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(rd_data == 8'h04, "R1 reset word", rd_data, 8'h04);
    chk(wdt_cnt_en && main_osc_en && !stop_grant && !stop_err, "R1 reset outputs",
        {wdt_cnt_en, main_osc_en, stop_grant, stop_err}, 4'b1100);
    measure(per);
    chk(per == 32, "R1 reset period", per, 32);

    // R2 and R3 ratio table
    for (int i = 0; i < 8; i++) begin
      wr(VW[i]);
      chk(int'(rd_data[2:0]) == VD[i], (VW[i][2:0] > 3'd4) ? "R3 code readback" : "R2 code readback",
          rd_data[2:0], VD[i]);
      measure(per);
      chk(per == VP[i], (VW[i][2:0] > 3'd4) ? "R3 period kept" : "R2 period", per, VP[i]);
    end

    // R8 stop bit ignored while main active
    wr(8'h82);
    chk(rd_data == 8'h02 && main_osc_en, "R8 stop ignored on main", rd_data, 8'h02);

    // R9 stop request on main
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
    chk(stop_grant == 1'b1, "R9 grant on main", stop_grant, 1);
    @(negedge clk);
    chk(stop_grant == 1'b0 && stop_err == 1'b0, "R9 grant one cycle", {stop_grant, stop_err}, 0);

    // R4 R5 switch to subsystem
    wr(8'h12);
    chk(rd_data == 8'h12, "R4 status deferred", rd_data, 8'h12);
    min_hi = 1000;
    mon_en = 1'b1;
    rises_until(1'b1, rises);
    chk(rises >= 4 && rises <= 6, "R4 edges before switch to sub", rises, 4);
    chk(rd_data == 8'h32, "R4 status on sub", rd_data, 8'h32);
    chk(wdt_cnt_en == 1'b0, "R7 watchdog off on sub", wdt_cnt_en, 0);
    measure(per);
    mon_en = 1'b0;
    chk(per == 16, "R6 sub period", per, 16);
    chk(min_hi >= 4, "R5 no short high pulse", min_hi, 4);

    // R6 divider ignored on sub
    wr(8'h10);
    chk(rd_data == 8'h30, "R6 code stored on sub", rd_data, 8'h30);
    measure(per);
    chk(per == 16, "R6 divider ignored", per, 16);

    // R8 oscillator stop on sub
    wr(8'h90);
    chk(rd_data == 8'hB0 && !main_osc_en, "R8 stop accepted on sub", rd_data, 8'hB0);
    measure(per);
    chk(per == 16, "R8 cpu clock kept on sub", per, 16);

    // R9 stop request on sub
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
    chk(stop_grant == 1'b0 && stop_err == 1'b1, "R9 refused on sub", {stop_grant, stop_err}, 1);
    repeat (5) @(negedge clk);
    chk(stop_err == 1'b1, "R9 error sticky", stop_err, 1);

    // R4 R8 back to main
    wr(8'h00);
    chk(rd_data[7] == 1'b0 && main_osc_en, "R8 stop cleared", rd_data[7], 0);
    chk(rd_data[5] == 1'b1, "R4 status still sub", rd_data[5], 1);
    rises_until(1'b0, rises);
    chk(rises >= 4 && rises <= 6, "R4 edges before switch to main", rises, 4);
    chk(rd_data == 8'h00 && wdt_cnt_en, "R7 watchdog on main", rd_data, 0);
    measure(per);
    chk(per == 2, "R2 main period after return", per, 2);

    // R10 asynchronous assert, synchronised release
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(rd_data == 8'h04 && !stop_err, "R10 async reset", rd_data, 8'h04);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wr_en = 1'b1;
    wr_data = 8'h01;
    repeat (2) @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    chk(rd_data == 8'h04, "R10 write during release ignored", rd_data, 8'h04);
    measure(per);
    chk(per == 32, "R1 period after reset", per, 32);

    summary();
  end
endmodule